// File: doc/BRIEF.md
# Character LCD Nibble-Write Sequencer

This block sits between a display controller and a character LCD module that is wired for a 4-bit, write-only bus. An upstream agent hands it one 8-bit item at a time, together with a flag that says whether the item is an instruction or display data. The block splits the item into two 4-bit transfers and strobes each one into the module with an enable pulse. It then holds the bus idle long enough for the module to finish its internal work before it accepts the next item.

Every interval is a whole number of system clock cycles. Each count is worked out at elaboration time from the clock frequency parameter and a target time in nanoseconds, rounded up, and is never less than one cycle. The clear-display instruction takes the module far longer to carry out, so it gets its own much longer idle wait. The power-up sequence, the choice of characters and any reads from the module belong to the upstream controller.

Top module: `lcd_nibble_seq`

## Requirements
- R1: `lcd_rs` takes the value of `req_is_data` (0 = instruction register, 1 = data register) on the clock edge that accepts an item. It holds that value through the whole transfer and the idle time after it.
- R2: `lcd_rw` is 0 at all times.
- R3: Each accepted item produces exactly two rising edges on `lcd_e`. During the first pulse `lcd_d` carries item bits 7:4, and during the second it carries bits 3:0.
- R4: `lcd_d` shows bits 7:4 from the acceptance edge onward. Each nibble and `lcd_rs` are stable for SETUP_CYC = ceil(SETUP_NS·CLK_HZ/1e9) cycles (at least 1) before `lcd_e` rises.
- R5: Each enable pulse stays high for exactly PULSE_CYC = ceil(PULSE_NS·CLK_HZ/1e9) cycles (at least 1).
- R6: From the fall of the first pulse to the rise of the second, `lcd_e` stays low for GAP_CYC + SETUP_CYC cycles. `lcd_d` changes to bits 3:0 SETUP_CYC cycles before the second rise, with GAP_CYC = ceil(GAP_NS·CLK_HZ/1e9).
- R7: After the second pulse falls, the block waits BYTE_CYC = ceil(BYTE_WAIT_NS·CLK_HZ/1e9) cycles before it raises `req_ready`. The full busy time for such an item is 2·SETUP_CYC + 2·PULSE_CYC + GAP_CYC + BYTE_CYC cycles.
- R8: An item with `req_is_data` = 0 and value 8'h01 (clear display) uses CLEAR_CYC = ceil(CLEAR_WAIT_NS·CLK_HZ/1e9) in place of BYTE_CYC. The value 8'h01 sent as data uses BYTE_CYC.
- R9: `req_ready` is high only when the block is idle. It falls on the acceptance edge and stays low until the post-item wait has ended. A request held high while the block is busy is accepted on the first edge at which `req_ready` is high, and it is never dropped.
- R10: During and after reset, `lcd_e` = 0, `lcd_d` = 0, `lcd_rs` = 0 and `req_ready` = 1.
- R11: `lcd_d` and `lcd_rs` do not change while `lcd_e` is high. When idle, they keep the last nibble and register select that were driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_HZ |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Upstream offers an item |
| req_is_data | input | 1 | 1 = display data, 0 = instruction |
| req_byte | input | 8 | Item to write |
| req_ready | output | 1 | Block is idle and accepts an item this cycle |
| lcd_e | output | 1 | Enable strobe to the module |
| lcd_rs | output | 1 | Register select to the module |
| lcd_rw | output | 1 | Read/write select, always write (0) |
| lcd_d | output | 4 | Data lines D7:D4 |

## Verification
The bench keeps `req_valid` high while the block is busy. A design that dropped that request, or took it a cycle early, would lose an item or cut the post-item idle time short. The bench measures the busy time for a clear instruction, for ordinary instructions and for data. It includes the value 8'h01 sent as data, which separates a clear detector that compares the full value and register select from one that tests only the value; the latter would stall that data item for the long wait. It also checks every cycle that the nibble order is high then low, the enable pulse width, the setup and gap lengths, and that the idle bus holds its last values. Nibbles sent in the wrong order, a pulse one cycle short, or data that moves while enable is high would each show up as a miscompare.

// File: rtl/lcd_seq_pkg.sv
// Shared types and timing arithmetic for the LCD nibble sequencer.
// Assumes every time target is given in nanoseconds and the clock in Hz.
package lcd_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SET_HI,
        ST_PUL_HI,
        ST_GAP,
        ST_SET_LO,
        ST_PUL_LO,
        ST_WAIT
    } seq_state_e;

    localparam logic [7:0] CMD_CLEAR = 8'h01;

    // Converts a time target to clock cycles, rounding up, never below one.
    function automatic longint unsigned ns_to_cycles(input longint unsigned ns,
                                                     input longint unsigned hz);
        longint unsigned c;
        c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
        if (c == 64'd0) c = 64'd1;
        return c;
    endfunction

endpackage

// File: rtl/lcd_cycle_timer.sv
// Single down-counter that sets the length of every sequencer phase.
// Assumes the caller loads (length - 1) so that a phase lasts exactly its length.
module lcd_cycle_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] count_q;

    // Load a new phase length or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (load)
            count_q <= load_val;
        else if (count_q != '0)
            count_q <= count_q - 1'b1;
    end

    assign expired = (count_q == '0);

endmodule

// File: rtl/lcd_seq_ctrl.sv
// Phase sequencer: accepts one item, walks through the setup, pulse, gap,
// setup, pulse and post-item wait phases, and drives registered bus outputs.
// Assumes the timer reports expiry in the last cycle of each phase.
module lcd_seq_ctrl
    import lcd_seq_pkg::*;
#(
    parameter int            CW       = 8,
    parameter logic [CW-1:0] LD_SETUP = '0,
    parameter logic [CW-1:0] LD_PULSE = '0,
    parameter logic [CW-1:0] LD_GAP   = '0,
    parameter logic [CW-1:0] LD_BYTE  = '0,
    parameter logic [CW-1:0] LD_CLEAR = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_is_data,
    input  logic [7:0]    req_byte,
    output logic          req_ready,
    input  logic          tmr_expired,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          lcd_e,
    output logic          lcd_rs,
    output logic [3:0]    lcd_d
);

    seq_state_e  state_q, state_nx;
    logic [7:0]  byte_q;
    logic        clr_q;
    logic        accept;
    logic [7:0]  cur_byte;
    logic        e_q, rs_q;
    logic [3:0]  d_q;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign cur_byte  = accept ? req_byte : byte_q;

    // Next-phase selection and timer reload at each phase boundary.
    always_comb begin
        state_nx = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: if (req_valid) begin
                state_nx = ST_SET_HI; tmr_load = 1'b1; tmr_val = LD_SETUP;
            end
            ST_SET_HI: if (tmr_expired) begin
                state_nx = ST_PUL_HI; tmr_load = 1'b1; tmr_val = LD_PULSE;
            end
            ST_PUL_HI: if (tmr_expired) begin
                state_nx = ST_GAP; tmr_load = 1'b1; tmr_val = LD_GAP;
            end
            ST_GAP: if (tmr_expired) begin
                state_nx = ST_SET_LO; tmr_load = 1'b1; tmr_val = LD_SETUP;
            end
            ST_SET_LO: if (tmr_expired) begin
                state_nx = ST_PUL_LO; tmr_load = 1'b1; tmr_val = LD_PULSE;
            end
            ST_PUL_LO: if (tmr_expired) begin
                state_nx = ST_WAIT; tmr_load = 1'b1;
                tmr_val  = clr_q ? LD_CLEAR : LD_BYTE;
            end
            ST_WAIT: if (tmr_expired) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Phase register and capture of the accepted item.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            byte_q  <= '0;
            clr_q   <= 1'b0;
        end else begin
            state_q <= state_nx;
            if (accept) begin
                byte_q <= req_byte;
                clr_q  <= !req_is_data && (req_byte == CMD_CLEAR);
            end
        end
    end

    // Glitch-free bus outputs, registered from the phase being entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q  <= 1'b0;
            rs_q <= 1'b0;
            d_q  <= '0;
        end else begin
            e_q <= (state_nx == ST_PUL_HI) || (state_nx == ST_PUL_LO);
            if (accept) rs_q <= req_is_data;
            unique case (state_nx)
                ST_SET_HI, ST_PUL_HI, ST_GAP: d_q <= cur_byte[7:4];
                ST_SET_LO, ST_PUL_LO, ST_WAIT: d_q <= cur_byte[3:0];
                default: d_q <= d_q;
            endcase
        end
    end

    assign lcd_e  = e_q;
    assign lcd_rs = rs_q;
    assign lcd_d  = d_q;

endmodule

// File: rtl/lcd_nibble_seq.sv
// Top level: turns byte requests into timed two-nibble writes on a 4-bit,
// write-only character LCD bus. All phase lengths derive from CLK_HZ.
// Assumes the upstream keeps req_byte and req_is_data stable while req_valid is high.
module lcd_nibble_seq
    import lcd_seq_pkg::*;
#(
    parameter int unsigned CLK_HZ        = 50_000_000,
    parameter int unsigned SETUP_NS      = 100,
    parameter int unsigned PULSE_NS      = 300,
    parameter int unsigned GAP_NS        = 1_000,
    parameter int unsigned BYTE_WAIT_NS  = 60_000,
    parameter int unsigned CLEAR_WAIT_NS = 1_640_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_is_data,
    input  logic [7:0] req_byte,
    output logic       req_ready,
    output logic       lcd_e,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic [3:0] lcd_d
);

    localparam longint unsigned SETUP_CYC = ns_to_cycles(SETUP_NS, CLK_HZ);
    localparam longint unsigned PULSE_CYC = ns_to_cycles(PULSE_NS, CLK_HZ);
    localparam longint unsigned GAP_CYC   = ns_to_cycles(GAP_NS, CLK_HZ);
    localparam longint unsigned BYTE_CYC  = ns_to_cycles(BYTE_WAIT_NS, CLK_HZ);
    localparam longint unsigned CLEAR_CYC = ns_to_cycles(CLEAR_WAIT_NS, CLK_HZ);
    localparam longint unsigned MAX_A = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam longint unsigned MAX_B = (GAP_CYC > BYTE_CYC) ? GAP_CYC : BYTE_CYC;
    localparam longint unsigned MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam longint unsigned MAX_CYC = (MAX_C > CLEAR_CYC) ? MAX_C : CLEAR_CYC;
    localparam int CW = $clog2(MAX_CYC + 1);

    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_expired;

    lcd_cycle_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    lcd_seq_ctrl #(
        .CW       (CW),
        .LD_SETUP (CW'(SETUP_CYC - 1)),
        .LD_PULSE (CW'(PULSE_CYC - 1)),
        .LD_GAP   (CW'(GAP_CYC - 1)),
        .LD_BYTE  (CW'(BYTE_CYC - 1)),
        .LD_CLEAR (CW'(CLEAR_CYC - 1))
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_is_data (req_is_data),
        .req_byte    (req_byte),
        .req_ready   (req_ready),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .lcd_e       (lcd_e),
        .lcd_rs      (lcd_rs),
        .lcd_d       (lcd_d)
    );

    assign lcd_rw = 1'b0;

endmodule

// File: rtl/lcd_nibble_seq_chk.sv
// Property checker for the LCD nibble sequencer, bound to its top level.
// Assumes PULSE_CYC matches the top's derived enable pulse length.
module lcd_nibble_seq_chk #(
    parameter longint unsigned PULSE_CYC = 1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       lcd_e,
    input logic       lcd_rs,
    input logic       lcd_rw,
    input logic [3:0] lcd_d
);

    logic [31:0] hi_len;

    // Length of the current enable-high run, seen one cycle after the fall.
    always_ff @(posedge clk) begin
        if (!rst_n)     hi_len <= '0;
        else if (lcd_e) hi_len <= hi_len + 1'b1;
        else            hi_len <= '0;
    end

    assert_rw_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_rw == 1'b0);

    assert_setup_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_e) |-> ($stable(lcd_d) && $stable(lcd_rs)));

    assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_e) |-> (hi_len == 32'(PULSE_CYC)));

    assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_idle_no_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !lcd_e);

    assert_bus_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_e && $past(lcd_e)) |-> ($stable(lcd_d) && $stable(lcd_rs)));

endmodule

bind lcd_nibble_seq lcd_nibble_seq_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .lcd_e     (lcd_e),
    .lcd_rs    (lcd_rs),
    .lcd_rw    (lcd_rw),
    .lcd_d     (lcd_d)
);

// File: tb/lcd_nibble_seq_bench.sv
// Bench: behavioural per-cycle reference model compared on every falling edge,
// plus measured busy lengths and strobe counts.
module lcd_nibble_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int unsigned T_HZ = 5_000_000;
    localparam int WDOG_LIMIT = 150_000;

    // Expected cycle count: ceil(ns * hz / 1e9), at least one.
    function automatic int cyc(input longint ns);
        longint c;
        c = (ns * longint'(T_HZ) + 999_999_999) / 1_000_000_000;
        return (c < 1) ? 1 : int'(c);
    endfunction

    localparam int S = cyc(100);
    localparam int P = cyc(300);
    localparam int G = cyc(1_000);
    localparam int W = cyc(60_000);
    localparam int C = cyc(1_640_000);
    localparam int BASE = 2 * S + 2 * P + G;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_is_data = 1'b0;
    logic [7:0] req_byte = 8'h00;
    logic       req_ready, lcd_e, lcd_rs, lcd_rw;
    logic [3:0] lcd_d;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    lcd_nibble_seq #(.CLK_HZ(T_HZ)) u_lcd_nibble_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_data(req_is_data),
        .req_byte(req_byte), .req_ready(req_ready), .lcd_e(lcd_e), .lcd_rs(lcd_rs),
        .lcd_rw(lcd_rw), .lcd_d(lcd_d)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Reference model state.
    bit       m_act = 1'b0;
    int       m_t = 0;
    int       m_tot = 0;
    bit [7:0] m_byte = 8'h00;
    bit       m_rs = 1'b0;
    bit       m_have = 1'b0;
    bit       m_acc = 1'b0;

    // Model advances on each rising edge, using only its own idea of readiness.
    always @(posedge clk) begin
        cycles++;
        m_acc = 1'b0;
        if (!rst_n) begin
            m_act = 1'b0; m_t = 0; m_byte = 8'h00; m_rs = 1'b0; m_have = 1'b0;
        end else if (m_act) begin
            m_t++;
            if (m_t == m_tot) m_act = 1'b0;
        end else if (req_valid) begin
            m_act  = 1'b1; m_t = 0; m_byte = req_byte; m_rs = req_is_data; m_have = 1'b1;
            m_tot  = BASE + ((!req_is_data && req_byte == 8'h01) ? C : W);
            m_acc  = 1'b1;
        end
        if (cycles > WDOG_LIMIT && !done) begin
            check(1'b0, "watchdog", cycles, WDOG_LIMIT);
            finish_run();
        end
    end

    int  e_rises = 0;
    bit  e_prev = 1'b0;

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit       xe;
            bit [3:0] xd;
            xe = 1'b0;
            xd = m_have ? m_byte[3:0] : 4'h0;
            if (m_act) begin
                if (m_t < S + P + G) xd = m_byte[7:4];
                else                  xd = m_byte[3:0];
                xe = ((m_t >= S) && (m_t < S + P)) ||
                     ((m_t >= S + P + G + S) && (m_t < BASE));
            end
            check(lcd_e == xe, "R5 enable timing", lcd_e, xe);
            check(lcd_d == xd, "R3 nibble", lcd_d, xd);
            check(lcd_rs == m_rs, "R1 register select", lcd_rs, m_rs);
            check(lcd_rw == 1'b0, "R2 write only", lcd_rw, 0);
            check(req_ready == !m_act, "R9 ready", req_ready, !m_act);
            if (lcd_e && !e_prev) e_rises++;
            e_prev = lcd_e;
        end
    end

    int busy_len;

    // Offer an item, keep it offered until accepted, then time the busy window.
    task automatic send(input bit is_data, input logic [7:0] b, input int exp_busy,
                        input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_is_data = is_data; req_byte = b;
        forever begin
            @(posedge clk); #1;
            if (m_acc) break;
        end
        req_valid = 1'b0;
        if (exp_busy > 0) begin
            busy_len = 0;
            forever begin
                @(negedge clk);
                if (req_ready) break;
                busy_len++;
            end
            check(busy_len == exp_busy, tag, busy_len, exp_busy);
        end
    endtask

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        check(lcd_e == 1'b0, "R10 e in reset", lcd_e, 0);
        check(lcd_d == 4'h0, "R10 d in reset", lcd_d, 0);
        check(lcd_rs == 1'b0, "R10 rs in reset", lcd_rs, 0);
        check(req_ready == 1'b1, "R10 ready in reset", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && lcd_e == 1'b0, "R10 idle after reset", req_ready, 1);

        // R3 R7: data item, then an instruction offered while busy (R9 hold-off)
        send(1'b1, 8'hA5, 0, "");
        send(1'b0, 8'h28, BASE + W, "R7 busy length");
        // R8: clear display takes the long wait
        send(1'b0, 8'h01, BASE + C, "R8 clear wait");
        // R8: the same value sent as data takes the short wait
        send(1'b1, 8'h01, BASE + W, "R8 data 01 short wait");
        send(1'b0, 8'h0C, BASE + W, "R7 busy length 0C");
        send(1'b1, 8'h3F, BASE + W, "R4 R6 data 3F");

        // R11: idle bus holds the last nibble and select
        repeat (20) @(negedge clk);
        check(lcd_d == 4'hF && lcd_rs == 1'b1, "R11 idle hold", lcd_d, 15);
        check(e_rises == 12, "R3 two strobes per item", e_rises, 12);
        finish_run();
    end

endmodule